// File: doc/BRIEF.md
# Checkpoint Write Log Buffer

This block sits beside a primary processor and watches every write it makes to data memory. Writes are appended to an ordered log and held there; none of them reaches the backup copy of data memory until the processor closes an execution interval with a commit strobe. The processor also dumps its register contents into data memory at that rollback point, and those dump writes are logged in the same way. On commit, the closed interval is replayed to the backup memory over a valid/ready write port as one batch, oldest entry first. The backup therefore only ever moves from one complete rollback state to the next.

Writes that arrive after a commit belong to the next interval and wait for the next commit. A commit that arrives while the previous batch is still being sent is remembered and starts as soon as that batch has gone. A failover input throws away everything not yet committed, so that the backup keeps the last committed state. If the log fills up, an overflow flag is raised and a commit is forced so that the log can drain.

The snoop port has no ready signal and cannot be stalled. The backup port follows the usual stream rules: an offered entry stays put until it is accepted, and an entry moves only in a cycle where both valid and ready are high. The backup side may hold ready low for as long as it needs.

Top module: `ckpt_log`

## Requirements
- R1: After reset, `bk_valid` and `overflow` are low and the log is empty.
- R2: Snooped writes that have not been committed never appear on the backup port. With no commit and no forced commit, `bk_valid` stays low.
- R3: After a commit, every write logged in the closed interval is sent on the backup port exactly once, in arrival order, carrying its address and data. A write in the same cycle as the commit strobe belongs to the closed interval. When two writes hit the same address, the later one is sent later.
- R4: While `bk_valid` is high and `bk_ready` is low, `bk_valid`, `bk_addr` and `bk_data` hold steady in the next cycle. An entry is transferred only in a cycle where both are high.
- R5: A commit that arrives while a batch is still being sent is held until that batch is finished, and then covers the writes logged up to its strobe. Writes logged after the strobe wait for a later commit.
- R6: `failover` discards every logged write that is not yet committed, including a write in the same cycle. Entries already committed are still sent. A later commit with no new writes sends nothing.
- R7: The log holds DEPTH entries. A write that fills the last free slot raises `overflow` and forces a commit that includes it. Writes that arrive while the log is full are dropped. `overflow` stays high until `failover`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Processor data-memory write seen this cycle |
| snp_addr | input | AW | Address of the snooped write |
| snp_data | input | DW | Data of the snooped write |
| commit | input | 1 | Rollback point reached; close the current interval |
| failover | input | 1 | Discard all uncommitted log entries |
| bk_valid | output | 1 | Backup write offered |
| bk_ready | input | 1 | Backup memory accepts the offered write |
| bk_addr | output | AW | Backup write address |
| bk_data | output | DW | Backup write data |
| overflow | output | 1 | Log reached full; sticky until failover |

## Verification
The bench builds the block with DEPTH = 8, AW = 16 and DW = 32. The shallow log lets a handful of held-off writes reach the last slot, so the forced commit, the dropped writes and the sticky flag are all exercised within a few cycles. Random addresses are drawn from only eight values, which makes repeated writes to one address common, so the ordering of overwrites is checked on every batch. Random throttling of ready keeps batches in flight while new commits and failovers arrive, which is how the deferred-commit path is reached.

// File: rtl/ckpt_log_pkg.sv
package ckpt_log_pkg;

  // What a commit request does in the cycle it is seen
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,  // no request
    ACT_OPEN  = 2'd1,  // idle: boundary moves at once, drain begins
    ACT_DEFER = 2'd2   // batch in flight: remember boundary for later
  } commit_act_e;

endpackage

// File: rtl/ckpt_log_store.sv
// Log storage: one write port from the snoop side, one asynchronous read
// port feeding the backup stream head.
module ckpt_log_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int EW   = AW + DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [EW-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[widx] <= {waddr, wdata};
  end

  assign {raddr, rdata} = slots[ridx];

endmodule

// File: rtl/ckpt_log_ctrl.sv
// Pointer control. Three positions on one ring:
//   rd_q   : next entry to send to the backup
//   mark_q : end of the committed region (send while rd_q != mark_q)
//   wr_q   : next free slot for a snooped write
// A commit seen while a batch is in flight parks its boundary in pmark_q.
module ckpt_log_ctrl
  import ckpt_log_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic          commit,
  input  logic          failover,
  input  logic          bk_ready,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          bk_valid,
  output logic          overflow,
  output logic          pend,
  output logic [PW-1:0] fill
);

  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);
  localparam logic [PW-1:0] LAST_L = PW'(DEPTH - 1);

  logic [PW-1:0] wr_q, rd_q, mark_q, pmark_q;
  logic          pend_q, ovf_q;

  logic [PW-1:0] wr_adv, back_to, mark_n, pmark_n;
  logic          full, accept, force_c, creq, busy, apply, pop, pend_n, ovf_n;
  commit_act_e   act;

  always_comb begin
    fill    = wr_q - rd_q;
    full    = (fill == FULL_L);
    accept  = snp_valid && !full;
    wr_adv  = wr_q + PW'(accept);
    force_c = accept && (fill == LAST_L);
    creq    = commit || force_c;
    busy    = (rd_q != mark_q);
    pop     = busy && bk_ready;
    apply   = pend_q && !busy;

    if (!creq)               act = ACT_NONE;
    else if (busy || pend_q) act = ACT_DEFER;
    else                     act = ACT_OPEN;

    // Where the write pointer falls back to on failover
    if (creq)        back_to = wr_adv;
    else if (pend_q) back_to = pmark_q;
    else             back_to = mark_q;

    mark_n  = mark_q;
    pmark_n = pmark_q;
    pend_n  = pend_q;
    if (apply) begin
      mark_n = pmark_q;
      pend_n = 1'b0;
    end
    case (act)
      ACT_OPEN:  mark_n = wr_adv;
      ACT_DEFER: begin
        pend_n  = 1'b1;
        pmark_n = wr_adv;
      end
      default: ;
    endcase

    if (failover)                        ovf_n = 1'b0;
    else if (force_c || (snp_valid && full)) ovf_n = 1'b1;
    else                                 ovf_n = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      mark_q  <= '0;
      pmark_q <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      rd_q    <= rd_q + PW'(pop);
      wr_q    <= failover ? back_to : wr_adv;
      mark_q  <= mark_n;
      pmark_q <= pmark_n;
      pend_q  <= pend_n;
      ovf_q   <= ovf_n;
    end
  end

  assign wr_en    = accept;
  assign wr_idx   = wr_q[IW-1:0];
  assign rd_idx   = rd_q[IW-1:0];
  assign bk_valid = busy;
  assign overflow = ovf_q;
  assign pend     = pend_q;

endmodule

// File: rtl/ckpt_log.sv
// Checkpoint write log: collects snooped data-memory writes per interval
// and replays each committed interval to the backup memory in order.
// DEPTH must be a power of two.
module ckpt_log #(
  parameter int DEPTH = 64,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  input  logic          commit,
  input  logic          failover,
  output logic          bk_valid,
  input  logic          bk_ready,
  output logic [AW-1:0] bk_addr,
  output logic [DW-1:0] bk_data,
  output logic          overflow
);

  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          pend_w;
  logic [PW-1:0] fill_w;

  ckpt_log_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .snp_valid(snp_valid),
    .commit   (commit),
    .failover (failover),
    .bk_ready (bk_ready),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .bk_valid (bk_valid),
    .overflow (overflow),
    .pend     (pend_w),
    .fill     (fill_w)
  );

  ckpt_log_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .widx (wr_idx),
    .waddr(snp_addr),
    .wdata(snp_data),
    .ridx (rd_idx),
    .raddr(bk_addr),
    .rdata(bk_data)
  );

endmodule

// File: rtl/ckpt_log_chk.sv
module ckpt_log_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          snp_valid,
  input logic          commit,
  input logic          failover,
  input logic          bk_valid,
  input logic          bk_ready,
  input logic [AW-1:0] bk_addr,
  input logic [DW-1:0] bk_data,
  input logic          overflow,
  input logic          pend,
  input logic [PW-1:0] fill
);

  // R4: offered entry holds under back-pressure
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid && !bk_ready) |=> (bk_valid && $stable(bk_addr) && $stable(bk_data)));

  // R2: nothing starts draining without a commit (explicit, forced or parked)
  p_no_spont_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bk_valid && !commit && !snp_valid && !pend) |=> !bk_valid);

  // R6: failover while idle leaves an empty log
  p_failover_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (failover && !commit && !snp_valid && !bk_valid && !pend) |=> (fill == '0 && !bk_valid));

  // R7: overflow flag is sticky until failover
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !failover) |=> overflow);

  // R7: log occupancy never exceeds its depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH));

endmodule

bind ckpt_log ckpt_log_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .snp_valid(snp_valid),
  .commit   (commit),
  .failover (failover),
  .bk_valid (bk_valid),
  .bk_ready (bk_ready),
  .bk_addr  (bk_addr),
  .bk_data  (bk_data),
  .overflow (overflow),
  .pend     (pend_w),
  .fill     (fill_w)
);

// File: tb/ckpt_log_test.sv
module ckpt_log_test;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic snp_valid = 1'b0, commit = 1'b0, failover = 1'b0, bk_ready = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;
  logic bk_valid, overflow;
  logic [AW-1:0] bk_addr;
  logic [DW-1:0] bk_data;

  ckpt_log #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_data(snp_data), .commit(commit), .failover(failover),
    .bk_valid(bk_valid), .bk_ready(bk_ready), .bk_addr(bk_addr),
    .bk_data(bk_data), .overflow(overflow));

  int checks = 0;
  int fails = 0;
  logic [AW+DW-1:0] unc_q[$];
  logic [AW+DW-1:0] exp_q[$];
  bit exp_ovf = 1'b0;
  bit rnd_ready = 1'b0;
  bit fix_ready = 1'b0;
  bit done = 1'b0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Ready source, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    bk_ready = rnd_ready ? 1'($urandom_range(0, 1)) : fix_ready;
  end

  // Stream monitor on the falling edge
  logic pv = 1'b0, pr = 1'b0;
  logic [AW+DW-1:0] pad = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        check("R4 hold valid", 64'(bk_valid), 64'd1);
        check("R4 hold payload", 64'({bk_addr, bk_data}), 64'(pad));
      end
      if (bk_valid && bk_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected entry: actual %0h expected none", {bk_addr, bk_data});
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check("R3 batch entry", 64'({bk_addr, bk_data}), 64'(e));
        end
      end
    end
    pv = bk_valid && rst_n;
    pr = bk_ready;
    pad = {bk_addr, bk_data};
  end

  // One cycle of stimulus plus the reference model update
  task automatic cyc(bit v, logic [AW-1:0] a, logic [DW-1:0] d, bit c, bit f);
    int fl;
    bit frc;
    fl = unc_q.size() + exp_q.size();
    frc = 1'b0;
    snp_valid = v; snp_addr = a; snp_data = d; commit = c; failover = f;
    if (v && !(f && !c && fl != DEPTH - 1)) begin
      if (fl == DEPTH) exp_ovf = 1'b1;
      else begin
        unc_q.push_back({a, d});
        if (fl == DEPTH - 1) begin frc = 1'b1; exp_ovf = 1'b1; end
      end
    end else if (v && fl == DEPTH) exp_ovf = 1'b1;
    if (c || frc) begin
      foreach (unc_q[i]) exp_q.push_back(unc_q[i]);
      unc_q.delete();
    end
    if (f) begin unc_q.delete(); exp_ovf = 1'b0; end
    @(posedge clk); #2;
    snp_valid = 1'b0; commit = 1'b0; failover = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic drain_wait(string req);
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) idle(1);
    idle(3);
    check({req, " all sent"}, 64'(exp_q.size()), 64'd0);
    check({req, " idle after batch"}, 64'(bk_valid), 64'd0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    check("R1 bk_valid after reset", 64'(bk_valid), 64'd0);
    check("R1 overflow after reset", 64'(overflow), 64'd0);

    // R2: writes without commit stay in the log
    fix_ready = 1'b1;
    wr(16'h0010, 32'hA0000001);
    wr(16'h0011, 32'hA0000002);
    wr(16'h0010, 32'hA0000003);
    idle(6);
    check("R2 no output before commit", 64'(bk_valid), 64'd0);

    // R3: commit with a same-cycle write to a repeated address
    cyc(1'b1, 16'h0011, 32'hA0000004, 1'b1, 1'b0);
    drain_wait("R3");

    // R4: back-pressure
    fix_ready = 1'b0;
    wr(16'h0020, 32'hB0000001);
    wr(16'h0021, 32'hB0000002);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    idle(5);
    check("R4 offered while stalled", 64'(bk_valid), 64'd1);
    fix_ready = 1'b1;
    drain_wait("R4");

    // R5: commit during drain is parked; later write waits
    fix_ready = 1'b0;
    wr(16'h0030, 32'hC0000001);
    wr(16'h0031, 32'hC0000002);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    wr(16'h0032, 32'hC0000003);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    wr(16'h0033, 32'hC0000004);
    fix_ready = 1'b1;
    drain_wait("R5");
    check("R5 later write still held", 64'(unc_q.size()), 64'd1);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    drain_wait("R5 next interval");

    // R6: failover drops uncommitted entries, committed batch continues
    fix_ready = 1'b0;
    wr(16'h0040, 32'hD0000001);
    wr(16'h0041, 32'hD0000002);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    wr(16'h0042, 32'hD0000003);
    wr(16'h0043, 32'hD0000004);
    cyc(1'b1, 16'h0044, 32'hD0000005, 1'b0, 1'b1);
    idle(2);
    check("R6 committed batch still offered", 64'(bk_valid), 64'd1);
    fix_ready = 1'b1;
    drain_wait("R6");
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    idle(4);
    check("R6 empty commit sends nothing", 64'(bk_valid), 64'd0);
    wr(16'h0045, 32'hD0000006);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    drain_wait("R6 after failover");

    // R7: fill the log, forced commit, dropped writes, sticky flag
    fix_ready = 1'b0;
    idle(2);
    for (int i = 0; i < DEPTH - 1; i++) wr(16'(16'h0050 + i), 32'hE0000000 + i);
    check("R7 no overflow below full", 64'(overflow), 64'd0);
    check("R7 no output before last slot", 64'(bk_valid), 64'd0);
    wr(16'h005F, 32'hE00000FF);
    idle(1);
    check("R7 overflow raised", 64'(overflow), 64'd1);
    check("R7 forced commit drains", 64'(bk_valid), 64'd1);
    wr(16'h0060, 32'hEEEEEEE1);
    wr(16'h0061, 32'hEEEEEEE2);
    check("R7 dropped writes not logged", 64'(unc_q.size()), 64'd0);
    fix_ready = 1'b1;
    drain_wait("R7");
    check("R7 overflow sticky", 64'(overflow), 64'(exp_ovf));
    cyc(1'b0, '0, '0, 1'b0, 1'b1);
    idle(1);
    check("R7 overflow cleared by failover", 64'(overflow), 64'd0);

    // Random intervals, random ready
    rnd_ready = 1'b1;
    for (int it = 0; it < 60; it++) begin
      int n;
      n = $urandom_range(0, 3);
      for (int j = 0; j < n; j++) wr(16'($urandom_range(0, 7)), $urandom);
      if ($urandom_range(0, 5) == 0) cyc(1'b0, '0, '0, 1'b0, 1'b1);
      else if ($urandom_range(0, 1) == 1) cyc(1'b1, 16'($urandom_range(0, 7)), $urandom, 1'b1, 1'b0);
      else cyc(1'b0, '0, '0, 1'b1, 1'b0);
      for (int k = 0; k < 200 && exp_q.size() > 3; k++) idle(1);
      idle($urandom_range(0, 2));
    end
    rnd_ready = 1'b0;
    fix_ready = 1'b1;
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    drain_wait("R3 random");
    check("R7 random overflow state", 64'(overflow), 64'(exp_ovf));
    done = 1'b1;
    report();
  end
endmodule